// File: doc/BRIEF.md
# Five-Valued Test Cube Intersection Unit

This block keeps the current test cube of a small, fixed network of two-input NAND gates for a fault-oriented test pattern search. Every net of the network holds one value of a five-valued fault algebra: logic 0, logic 1, unspecified (X), D (the net is 1 when the circuit is fault-free and 0 when it is faulty) or D-bar (the reverse). A separate code marks an empty, contradictory position. The model covers a single fault, so one D variable is enough.

When the search controller raises a strobe, the unit intersects the incoming cube with the stored one, net by net. If every position intersects without contradiction, the result replaces the stored cube. If any position comes out empty, the stored cube stays as it was and a one-cycle conflict pulse tells the controller to backtrack. At all times the unit drives the D-frontier: one bit per gate, set when that gate's output is still unspecified and a fault effect reaches one of its inputs. A synchronous clear sets every net back to X.

The network is computed from two parameters: `NUM_PI` primary inputs are nets 0 to NUM_PI-1, and gate g reads nets g and g+1 and drives net NUM_PI+g.

Top module: `dcube_unit`

## Requirements
- R1: After reset every net of `cube_q` holds X, `conflict` is low and `frontier` is all zero. Net n occupies bits [3n+2:3n]; codes are 0=3'b000, 1=3'b001, X=3'b010, D=3'b011, D-bar=3'b100, empty=3'b111.
- R2: Intersecting X with any value v of 0, 1, D or D-bar yields v, whichever of the two cubes holds the X.
- R3: Intersecting a value with an identical value (0, 1, X, D or D-bar) yields that value.
- R4: These pairs intersect to empty: 0 with 1; D with 0, 1 or D-bar; D-bar with 0, 1 or D. An incoming position holding the empty code or an unused code (3'b101, 3'b110) also intersects to empty.
- R5: A strobe whose intersection has at least one empty position leaves `cube_q` unchanged and raises `conflict` for exactly the one cycle after that strobe's clock edge.
- R6: A strobe whose intersection has no empty position loads the whole result into `cube_q` at that clock edge, with `conflict` low in the following cycle; the stored cube never holds the empty code.
- R7: `frontier[g]` is high exactly when net NUM_PI+g holds X and net g or net g+1 holds D or D-bar.
- R8: `clear` sets every net to X at the next clock edge, takes priority over a strobe in the same cycle, and produces no conflict pulse.
- R9: With neither `strobe` nor `clear` high, `cube_q` holds its value and `conflict` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous load of X into every net |
| strobe | input | 1 | Intersect `in_cube` with the stored cube |
| in_cube | input | 3*(NUM_PI+NUM_GATES) | Incoming cube, 3 bits per net |
| cube_q | output | 3*(NUM_PI+NUM_GATES) | Stored test cube |
| conflict | output | 1 | One-cycle backtrack request after an empty intersection |
| frontier | output | NUM_GATES | D-frontier, one bit per gate |

## Verification
The bench drives mixed cubes in which only one position contradicts, for example D against D-bar or 1 against 0 among many agreeing nets; a design that commits the agreeing positions partially, or flags only some kinds of mismatch, leaves a changed cube or no conflict pulse. It feeds the empty and unused codes in the incoming cube, which an X-passes-through shortcut would silently store. It walks the frontier as fault effects reach gate inputs and as gate outputs become specified, catching a frontier that ignores D-bar or forgets the output-unspecified condition, and it raises clear together with a conflicting strobe to expose wrong priority or a stray conflict pulse.

// File: rtl/dcube_pkg.sv
package dcube_pkg;

    localparam int VW = 3;

    localparam logic [VW-1:0] V_ZERO  = 3'b000;
    localparam logic [VW-1:0] V_ONE   = 3'b001;
    localparam logic [VW-1:0] V_X     = 3'b010;
    localparam logic [VW-1:0] V_D     = 3'b011;
    localparam logic [VW-1:0] V_DBAR  = 3'b100;
    localparam logic [VW-1:0] V_EMPTY = 3'b111;

    // true for the five legal net values
    function automatic logic is_legal(input logic [VW-1:0] v);
        return (v <= V_DBAR);
    endfunction

    // true when the value carries a fault effect
    function automatic logic is_fault(input logic [VW-1:0] v);
        return (v == V_D) || (v == V_DBAR);
    endfunction

endpackage

// File: rtl/dcube_meet.sv
module dcube_meet
    import dcube_pkg::*;
#(
    parameter int NUM_NETS = 10
) (
    input  logic [NUM_NETS*VW-1:0] cur_cube,
    input  logic [NUM_NETS*VW-1:0] new_cube,
    output logic [NUM_NETS*VW-1:0] meet_cube,
    output logic [NUM_NETS-1:0]    empty_mask
);

    for (genvar n = 0; n < NUM_NETS; n++) begin : g_net
        logic [VW-1:0] lhs;
        logic [VW-1:0] rhs;
        logic [VW-1:0] res;

        assign lhs = cur_cube[n*VW +: VW];
        assign rhs = new_cube[n*VW +: VW];

        always_comb begin
            if (!is_legal(lhs) || !is_legal(rhs)) begin
                res = V_EMPTY;
            end else if (lhs == V_X) begin
                res = rhs;
            end else if (rhs == V_X) begin
                res = lhs;
            end else if (lhs == rhs) begin
                res = lhs;
            end else begin
                res = V_EMPTY;
            end
        end

        assign meet_cube[n*VW +: VW] = res;
        assign empty_mask[n]         = (res == V_EMPTY);

        // R4
        always_comb begin
            if (is_legal(lhs) && is_legal(rhs) && lhs != V_X && rhs != V_X && lhs != rhs) begin
                mismatch_empty_chk: assert (empty_mask[n]);
            end
        end
    end

endmodule

// File: rtl/dcube_frontier.sv
module dcube_frontier
    import dcube_pkg::*;
#(
    parameter int NUM_PI    = 4,
    parameter int NUM_GATES = 6
) (
    input  logic [(NUM_PI+NUM_GATES)*VW-1:0] cube,
    output logic [NUM_GATES-1:0]             frontier
);

    for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
        localparam int IA = g;
        localparam int IB = g + 1;
        localparam int IO = NUM_PI + g;

        logic [VW-1:0] in_a;
        logic [VW-1:0] in_b;
        logic [VW-1:0] out_v;

        assign in_a  = cube[IA*VW +: VW];
        assign in_b  = cube[IB*VW +: VW];
        assign out_v = cube[IO*VW +: VW];

        assign frontier[g] = (out_v == V_X) && (is_fault(in_a) || is_fault(in_b));
    end

endmodule

// File: rtl/dcube_unit.sv
module dcube_unit
    import dcube_pkg::*;
#(
    parameter int NUM_PI    = 4,
    parameter int NUM_GATES = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 clear,
    input  logic                                 strobe,
    input  logic [(NUM_PI+NUM_GATES)*VW-1:0]     in_cube,
    output logic [(NUM_PI+NUM_GATES)*VW-1:0]     cube_q,
    output logic                                 conflict,
    output logic [NUM_GATES-1:0]                 frontier
);

    localparam int NUM_NETS = NUM_PI + NUM_GATES;
    localparam int CW       = NUM_NETS * VW;
    localparam logic [CW-1:0] ALL_X = {NUM_NETS{V_X}};

    typedef struct packed {
        logic [CW-1:0] cube;
        logic          conflict;
    } state_t;

    state_t st_d, st_q;

    logic [CW-1:0]       meet_y;
    logic [NUM_NETS-1:0] empty_mask;
    logic                any_empty;

    dcube_meet #(.NUM_NETS(NUM_NETS)) u_meet (
        .cur_cube   (st_q.cube),
        .new_cube   (in_cube),
        .meet_cube  (meet_y),
        .empty_mask (empty_mask)
    );

    dcube_frontier #(.NUM_PI(NUM_PI), .NUM_GATES(NUM_GATES)) u_front (
        .cube     (st_q.cube),
        .frontier (frontier)
    );

    assign any_empty = |empty_mask;

    always_comb begin
        st_d          = st_q;
        st_d.conflict = 1'b0;
        if (clear) begin
            st_d.cube = ALL_X;
        end else if (strobe) begin
            if (any_empty) begin
                st_d.conflict = 1'b1;
            end else begin
                st_d.cube = meet_y;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cube     <= ALL_X;
            st_q.conflict <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cube_q   = st_q.cube;
    assign conflict = st_q.conflict;

    function automatic logic holds_empty(input logic [CW-1:0] c);
        logic hit;
        hit = 1'b0;
        for (int n = 0; n < NUM_NETS; n++) begin
            if (c[n*VW +: VW] == V_EMPTY) hit = 1'b1;
        end
        return hit;
    endfunction

    function automatic logic holds_fault(input logic [CW-1:0] c);
        logic hit;
        hit = 1'b0;
        for (int n = 0; n < NUM_NETS; n++) begin
            if (is_fault(c[n*VW +: VW])) hit = 1'b1;
        end
        return hit;
    endfunction

    // R8
    clear_loads_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cube_q == ALL_X) && !conflict);

    // R5
    conflict_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !clear && any_empty) |=> conflict && (cube_q == $past(cube_q)));

    // R6
    commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !clear && !any_empty) |=> !conflict && (cube_q == $past(meet_y)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe && !clear) |=> $stable(cube_q) && !conflict);

    // R6
    no_empty_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !holds_empty(cube_q));

    // R7
    frontier_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|frontier) |-> holds_fault(cube_q));

endmodule

// File: tb/dcube_unit_test.sv
module dcube_unit_test;
    import dcube_pkg::*;

    localparam int NPI = 4;
    localparam int NG  = 6;
    localparam int NN  = NPI + NG;
    localparam int CW  = NN * VW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear = 1'b0;
    logic          strobe = 1'b0;
    logic [CW-1:0] in_cube = '0;
    logic [CW-1:0] cube_q;
    logic          conflict;
    logic [NG-1:0] frontier;

    int checks = 0;
    int fails  = 0;
    logic [CW-1:0] model;

    dcube_unit #(.NUM_PI(NPI), .NUM_GATES(NG)) uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .strobe(strobe),
        .in_cube(in_cube), .cube_q(cube_q), .conflict(conflict), .frontier(frontier)
    );

    always #10 clk = ~clk;

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    function automatic logic [CW-1:0] all_x();
        return {NN{V_X}};
    endfunction

    function automatic logic [CW-1:0] put(input logic [CW-1:0] c, input int n, input logic [2:0] v);
        logic [CW-1:0] r;
        r = c;
        r[n*VW +: VW] = v;
        return r;
    endfunction

    function automatic logic [NG-1:0] exp_frontier(input logic [CW-1:0] c);
        logic [NG-1:0] f;
        for (int g = 0; g < NG; g++) begin
            logic [2:0] a, b, o;
            a = c[g*VW +: VW];
            b = c[(g+1)*VW +: VW];
            o = c[(NPI+g)*VW +: VW];
            f[g] = (o == V_X) && (a == V_D || a == V_DBAR || b == V_D || b == V_DBAR);
        end
        return f;
    endfunction

    task automatic check_vec(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cube: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input string what, input logic [NG-1:0] act, input logic [NG-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // one strobe; returns after the edge that takes it, sampled at the next negedge
    task automatic apply(input logic [CW-1:0] c);
        @(negedge clk);
        in_cube = c;
        strobe  = 1'b1;
        @(negedge clk);
        strobe  = 1'b0;
    endtask

    task automatic expect_commit(input string req, input logic [CW-1:0] c, input logic [CW-1:0] exp);
        apply(c);
        model = exp;
        check_vec(req, cube_q, exp);
        check_bit(req, "conflict", {{(NG-1){1'b0}}, conflict}, '0);
        check_bit("R7", "frontier", frontier, exp_frontier(exp));
    endtask

    task automatic expect_conflict(input string req, input logic [CW-1:0] c);
        apply(c);
        check_vec(req, cube_q, model);
        check_bit(req, "conflict", {{(NG-1){1'b0}}, conflict}, 1);
        @(negedge clk);
        check_bit("R5", "conflict width", {{(NG-1){1'b0}}, conflict}, '0);
        check_vec("R5", cube_q, model);
    endtask

    task automatic t_reset();
        check_vec("R1", cube_q, all_x());
        check_bit("R1", "conflict", {{(NG-1){1'b0}}, conflict}, '0);
        check_bit("R1", "frontier", frontier, '0);
        model = all_x();
    endtask

    task automatic t_commit_basic();
        logic [CW-1:0] c;
        c = put(put(put(put(all_x(), 0, V_ZERO), 1, V_ONE), 2, V_D), 3, V_DBAR);
        expect_commit("R2", c, c);
        // stored values meet X from the incoming side
        expect_commit("R2", all_x(), c);
        // identical values keep
        expect_commit("R3", c, c);
        // X met with X on remaining nets, plus more specification
        expect_commit("R6", put(c, 9, V_ONE), put(c, 9, V_ONE));
    endtask

    task automatic t_conflicts();
        logic [CW-1:0] base;
        base = model;
        expect_conflict("R4", put(base, 1, V_ZERO));     // 1 vs 0
        expect_conflict("R4", put(base, 0, V_ONE));      // 0 vs 1
        expect_conflict("R4", put(base, 2, V_DBAR));     // D vs D-bar
        expect_conflict("R4", put(base, 2, V_ONE));      // D vs 1
        expect_conflict("R4", put(base, 3, V_ZERO));     // D-bar vs 0
        expect_conflict("R4", put(base, 3, V_D));        // D-bar vs D
        expect_conflict("R4", put(base, 6, V_EMPTY));    // empty code onto X
        expect_conflict("R4", put(base, 7, 3'b101));     // unused code onto X
        expect_conflict("R4", put(all_x(), 8, 3'b110));  // unused code alone
    endtask

    task automatic t_idle();
        @(negedge clk);
        in_cube = put(all_x(), 1, V_ZERO);
        @(negedge clk);
        @(negedge clk);
        check_vec("R9", cube_q, model);
        check_bit("R9", "conflict", {{(NG-1){1'b0}}, conflict}, '0);
    endtask

    task automatic t_clear(input logic with_strobe);
        @(negedge clk);
        clear   = 1'b1;
        strobe  = with_strobe;
        in_cube = put(model, 0, V_ONE == model[0 +: VW] ? V_ZERO : V_ONE);
        @(negedge clk);
        clear  = 1'b0;
        strobe = 1'b0;
        model  = all_x();
        check_vec("R8", cube_q, all_x());
        check_bit("R8", "conflict", {{(NG-1){1'b0}}, conflict}, '0);
        check_bit("R8", "frontier", frontier, '0);
    endtask

    task automatic t_frontier();
        logic [CW-1:0] c;
        c = put(all_x(), 1, V_D);
        expect_commit("R7", c, c);
        check_bit("R7", "frontier two", frontier, 6'b000011);
        c = put(c, 5, V_ONE);
        expect_commit("R7", c, c);
        check_bit("R7", "frontier out set", frontier, 6'b000001);
        c = put(c, 4, V_DBAR);
        expect_commit("R7", c, c);
        check_bit("R7", "frontier dbar", frontier, 6'b011000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_commit_basic();
        t_conflicts();
        t_idle();
        t_clear(1'b1);
        t_frontier();
        t_clear(1'b0);
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule